// File: doc/BRIEF.md
# Serial Word EEPROM Device Model

This block is a synthesizable device-side model of a small serial EEPROM organised as 16-bit words. It runs entirely on a fast system clock and oversamples four asynchronous host lines: an active-low select, a serial clock, a serial data input and a write-protect line. Each instruction is a 4-bit start pattern, a 4-bit command, an 8-bit address and, for writes, one data word. Four commands are served: read, write, write enable and write disable.

Reads stream words continuously with an incrementing address for as long as the host keeps clocking. Writes are gated by a write-enable latch and run a self-timed program cycle whose length is a parameter in system-clock cycles. Ready/busy is shown on a dedicated pin and can also be presented on the data output. The data output has a separate enable that models a high-impedance pin.

Top module: `eep_serial_slave`

## Requirements
- R1: After reset every word reads FFFFh, the ready output is high, the data output enable is low and the write latch is disabled.
- R2: A frame whose first four bits (first sent bit first) differ from 1010, or whose command code is none of 1000 (read), 0100 (write), 0011 (enable), 0000 (disable), is ignored until the select is released.
- R3: Address bits are sent least significant first; for a read, bit 0 of the addressed word is driven on the falling serial-clock edge that ends the 16th clock, then one bit per falling edge, least significant first, with the output enable high.
- R4: While clocking continues, a read presents the next word every 16 clocks, the address wrapping from the top word to word 0.
- R5: A write issued while the write latch is disabled leaves the word unchanged and never raises busy; reset and the disable command clear the latch.
- R6: The enable and disable commands act regardless of the write-protect line and of their address field.
- R7: A write frame raises busy (ready low) after the rising edge of the 32nd clock; busy lasts PROG_CYCLES system clocks, and the word is stored when it ends.
- R8: An instruction whose select falls while busy is ignored in full, even if busy ends before the frame completes.
- R9: Write-protect high at any point of a write frame before the 32nd clock, or releasing select before it, cancels the write: no busy, word unchanged.
- R10: Write-protect high during the program cycle ends busy early and leaves the word unchanged.
- R11: After a write, a select falling while the serial clock is low drives the data output with the ready state (low busy, high ready) until the next serial-clock rise or select release; otherwise the output enable is low outside read data and after select release.
- R12: After a completed enable, disable or write frame, further clocks are ignored until the select has been released once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low device select from the host |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data into the device |
| wprot_i | input | 1 | Write protect; high cancels or aborts writes |
| sdo_o | output | 1 | Serial data or ready/busy out of the device |
| sdo_oe_o | output | 1 | Output enable of the data pin; low means high impedance |
| rdy_o | output | 1 | High when ready, low during the program cycle |

## Verification
Every host edge reaches the logic through two synchronizer flops and one edge-detect flop, so a response is due three to four system clocks after the line changes; the bench holds each serial-clock phase for eight system clocks and reads the data output on the last cycle of the low phase, which lands after the falling edge that produced it and before the next rising edge. Busy is checked about 24 cycles after the committing edge and again 60 cycles later, both inside the program time, and ready is then awaited within a bounded window. Every stored word is swept, with expected contents computed arithmetically in the bench and compared through reads that cross the top of the array.

// File: rtl/eep_pkg.sv
package eep_pkg;

   typedef enum logic [3:0] {
      CMD_READ   = 4'b1000,
      CMD_WRITE  = 4'b0100,
      CMD_WR_ON  = 4'b0011,
      CMD_WR_OFF = 4'b0000
   } eep_cmd_e;

   localparam logic [3:0] START_CODE  = 4'b1010;
   localparam int         START_BITS  = 4;
   localparam int         CMD_BITS    = 4;
   localparam int         ADDR_FIELD  = 8;

   function automatic logic cmd_known(input logic [3:0] code);
      return (code == CMD_READ) || (code == CMD_WRITE) ||
             (code == CMD_WR_ON) || (code == CMD_WR_OFF);
   endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
   parameter int               W       = 4,
   parameter int               STAGES  = 2,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("eep_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RST_VAL;
      else        stg[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= RST_VAL;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/eep_edge_det.sv
module eep_edge_det #(
   parameter int           W       = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);

   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;
   assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
   parameter int CYCLES = 2_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic abort_i,
   output logic busy_o,
   output logic done_o
);

   localparam int CNT_W = $clog2(CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

   if (CYCLES < 2) begin : g_bad_cycles
      $error("eep_prog_timer: CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         done_o <= 1'b0;
         cnt_q  <= '0;
      end else begin
         done_o <= 1'b0;
         if (!busy_o) begin
            if (start_i) begin
               busy_o <= 1'b1;
               cnt_q  <= '0;
            end
         end else if (abort_i) begin
            busy_o <= 1'b0;
         end else if (cnt_q == LAST) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R7
   prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (cnt_q < CNT_W'(CYCLES)));

   // R10
   abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && abort_i) |=> (!busy_o && !done_o));

endmodule

// File: rtl/eep_word_array.sv
module eep_word_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_a_i,
   output logic [DATA_W-1:0] rdata_a_o,
   input  logic [ADDR_W-1:0] raddr_b_i,
   output logic [DATA_W-1:0] rdata_b_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                     mem[w] <= '1;
         else if (we_i && (waddr_i == ADDR_W'(w)))       mem[w] <= wdata_i;
      end
   end

   assign rdata_a_o = mem[raddr_a_i];
   assign rdata_b_o = mem[raddr_b_i];

   // R7
   store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (mem[$past(waddr_i)] == $past(wdata_i)));

endmodule

// File: rtl/eep_serial_slave.sv
module eep_serial_slave #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16,
   parameter int PROG_CYCLES = 2_500_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_n_i,
   input  logic sck_i,
   input  logic sdi_i,
   input  logic wprot_i,
   output logic sdo_o,
   output logic sdo_oe_o,
   output logic rdy_o
);
   import eep_pkg::*;

   localparam int ADR_FIRST_I = START_BITS + CMD_BITS;
   localparam int DAT_FIRST_I = ADR_FIRST_I + ADDR_FIELD;
   localparam int FRAME_BITS  = DAT_FIRST_I + DATA_W;
   localparam int CNT_W       = $clog2(FRAME_BITS + 1);
   localparam int RB_W        = $clog2(DATA_W);

   localparam logic [CNT_W-1:0] C_START_LAST = CNT_W'(START_BITS - 1);
   localparam logic [CNT_W-1:0] C_CMD_LAST   = CNT_W'(ADR_FIRST_I - 1);
   localparam logic [CNT_W-1:0] C_ADR_FIRST  = CNT_W'(ADR_FIRST_I);
   localparam logic [CNT_W-1:0] C_ADR_LAST   = CNT_W'(DAT_FIRST_I - 1);
   localparam logic [CNT_W-1:0] C_DAT_FIRST  = CNT_W'(DAT_FIRST_I);
   localparam logic [CNT_W-1:0] C_DAT_LAST   = CNT_W'(FRAME_BITS - 1);
   localparam logic [RB_W-1:0]  RB_LAST      = RB_W'(DATA_W - 1);

   if (ADDR_W < 1 || ADDR_W > ADDR_FIELD) begin : g_bad_addr
      $error("eep_serial_slave: ADDR_W must lie in 1..8");
   end
   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("eep_serial_slave: DATA_W must be a power of two, at least 2");
   end

   // ---------------- input conditioning ----------------
   logic [3:0] pins_s;
   logic       sel_n_s, sck_s, sdi_s, wprot_s;
   logic [1:0] ctl_rise, ctl_fall;
   logic       desel_edge, sel_edge, sck_rise, sck_fall;

   eep_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({wprot_i, sdi_i, sck_i, sel_n_i}),
      .q_o   (pins_s)
   );

   assign sel_n_s = pins_s[0];
   assign sck_s   = pins_s[1];
   assign sdi_s   = pins_s[2];
   assign wprot_s = pins_s[3];

   eep_edge_det #(.W(2), .RST_VAL(2'b01)) i_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  ({sck_s, sel_n_s}),
      .rise_o (ctl_rise),
      .fall_o (ctl_fall)
   );

   assign desel_edge = ctl_rise[0];
   assign sel_edge   = ctl_fall[0];
   assign sck_rise   = ctl_rise[1];
   assign sck_fall   = ctl_fall[1];

   // ---------------- frame state ----------------
   logic [CNT_W-1:0]  bit_cnt;
   logic [3:0]        code_sr;
   eep_cmd_e          cmd_q;
   logic [ADDR_W-1:0] adr_q, nxt_adr;
   logic [DATA_W-1:0] dat_q, nxt_dat;
   logic              lock_q, wel_q, wcancel_q;
   logic              stat_arm_q, stat_mode_q;
   logic [ADDR_W-1:0] wr_addr_q;
   logic [DATA_W-1:0] wr_data_q;
   logic              prog_start_q;

   logic              rd_active_q, rd_oe_q, rd_q;
   logic [DATA_W-1:0] rd_sr;
   logic [RB_W-1:0]   rd_bit_q;
   logic [ADDR_W-1:0] rd_addr_q;

   logic              busy, prog_done, selected, take;
   logic [DATA_W-1:0] rdata_a, rdata_b;
   logic [CNT_W-1:0]  adr_pos, dat_pos;
   logic              in_adr, in_dat;
   logic [3:0]        code_nxt;

   assign selected = ~sel_n_s;
   assign take     = sck_rise && selected && !lock_q && !busy;
   assign adr_pos  = bit_cnt - C_ADR_FIRST;
   assign dat_pos  = bit_cnt - C_DAT_FIRST;
   assign in_adr   = (bit_cnt >= C_ADR_FIRST) && (bit_cnt <= C_ADR_LAST);
   assign in_dat   = (bit_cnt >= C_DAT_FIRST) && (bit_cnt <= C_DAT_LAST);
   assign code_nxt = {code_sr[2:0], sdi_s};

   always_comb begin
      for (int k = 0; k < ADDR_W; k++)
         nxt_adr[k] = (in_adr && adr_pos == CNT_W'(k)) ? sdi_s : adr_q[k];
      for (int k = 0; k < DATA_W; k++)
         nxt_dat[k] = (in_dat && dat_pos == CNT_W'(k)) ? sdi_s : dat_q[k];
   end

   // ---------------- instruction engine ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt      <= '0;
         code_sr      <= '0;
         cmd_q        <= CMD_WR_OFF;
         adr_q        <= '0;
         dat_q        <= '0;
         lock_q       <= 1'b0;
         wel_q        <= 1'b0;
         wcancel_q    <= 1'b0;
         stat_arm_q   <= 1'b0;
         stat_mode_q  <= 1'b0;
         wr_addr_q    <= '0;
         wr_data_q    <= '0;
         prog_start_q <= 1'b0;
         rd_active_q  <= 1'b0;
         rd_oe_q      <= 1'b0;
         rd_q         <= 1'b0;
         rd_sr        <= '0;
         rd_bit_q     <= '0;
         rd_addr_q    <= '0;
      end else begin
         prog_start_q <= 1'b0;
         if (desel_edge) begin
            bit_cnt     <= '0;
            lock_q      <= 1'b0;
            wcancel_q   <= 1'b0;
            rd_active_q <= 1'b0;
            rd_oe_q     <= 1'b0;
            stat_mode_q <= 1'b0;
         end else if (sel_edge) begin
            bit_cnt     <= '0;
            lock_q      <= busy;
            wcancel_q   <= 1'b0;
            rd_active_q <= 1'b0;
            rd_oe_q     <= 1'b0;
            if (stat_arm_q && !sck_s) stat_mode_q <= 1'b1;
         end else begin
            if (sck_rise && selected) stat_mode_q <= 1'b0;

            if (take) begin
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == '0) stat_arm_q <= 1'b0;
               if (bit_cnt <= C_CMD_LAST) begin
                  code_sr <= code_nxt;
                  if (bit_cnt == C_START_LAST && code_nxt != START_CODE)
                     lock_q <= 1'b1;
                  if (bit_cnt == C_CMD_LAST) begin
                     cmd_q <= eep_cmd_e'(code_nxt);
                     if (!cmd_known(code_nxt)) lock_q <= 1'b1;
                  end
               end else if (in_adr) begin
                  adr_q <= nxt_adr;
                  if (bit_cnt == C_ADR_LAST) begin
                     case (cmd_q)
                        CMD_READ: begin
                           rd_sr       <= rdata_a;
                           rd_addr_q   <= nxt_adr;
                           rd_bit_q    <= '0;
                           rd_active_q <= 1'b1;
                           lock_q      <= 1'b1;
                        end
                        CMD_WR_ON: begin
                           wel_q  <= 1'b1;
                           lock_q <= 1'b1;
                        end
                        CMD_WR_OFF: begin
                           wel_q  <= 1'b0;
                           lock_q <= 1'b1;
                        end
                        default: ;
                     endcase
                  end
               end else begin
                  dat_q <= nxt_dat;
                  if (bit_cnt == C_DAT_LAST) begin
                     lock_q <= 1'b1;
                     if (wel_q && !wcancel_q && !wprot_s) begin
                        prog_start_q <= 1'b1;
                        wr_addr_q    <= adr_q;
                        wr_data_q    <= nxt_dat;
                        stat_arm_q   <= 1'b1;
                     end
                  end
               end
            end

            if (selected && !lock_q && cmd_q == CMD_WRITE &&
                bit_cnt > C_CMD_LAST && wprot_s)
               wcancel_q <= 1'b1;

            if (sck_fall && rd_active_q && selected) begin
               rd_oe_q <= 1'b1;
               rd_q    <= rd_sr[0];
               if (rd_bit_q == RB_LAST) begin
                  rd_sr     <= rdata_b;
                  rd_addr_q <= rd_addr_q + 1'b1;
                  rd_bit_q  <= '0;
               end else begin
                  rd_sr    <= rd_sr >> 1;
                  rd_bit_q <= rd_bit_q + 1'b1;
               end
            end
         end
      end
   end

   // ---------------- storage and program timer ----------------
   eep_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (prog_done),
      .waddr_i   (wr_addr_q),
      .wdata_i   (wr_data_q),
      .raddr_a_i (nxt_adr),
      .rdata_a_o (rdata_a),
      .raddr_b_i (rd_addr_q + 1'b1),
      .rdata_b_o (rdata_b)
   );

   eep_prog_timer #(.CYCLES(PROG_CYCLES)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (prog_start_q),
      .abort_i (wprot_s),
      .busy_o  (busy),
      .done_o  (prog_done)
   );

   assign rdy_o    = ~busy;
   assign sdo_oe_o = stat_mode_q | rd_oe_q;
   assign sdo_o    = stat_mode_q ? ~busy : rd_q;

   // R5
   wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> wel_q);

   // R8
   busy_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !rd_active_q);

   // R11
   deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desel_edge |=> !sdo_oe_o);

   // R12
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_rise && lock_q && !desel_edge && !sel_edge) |=> $stable(bit_cnt));

endmodule

// File: tb/test_eep_serial_slave.sv
module test_eep_serial_slave;

   localparam int AW = 4;
   localparam int NW = 1 << AW;
   localparam int PC = 100;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, sel_n, sck, sdi, wprot;
   logic sdo, oe, rdy;

   eep_serial_slave #(.ADDR_W(AW), .DATA_W(16), .PROG_CYCLES(PC), .SYNC_STAGES(2)) i_eep_serial_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_n_i  (sel_n),
      .sck_i    (sck),
      .sdi_i    (sdi),
      .wprot_i  (wprot),
      .sdo_o    (sdo),
      .sdo_oe_o (oe),
      .rdy_o    (rdy)
   );

   int n_chk  = 0;
   int n_fail = 0;
   logic [15:0] model [NW];
   logic last_sdo, last_oe;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one serial clock: 8 system clocks low, 8 high
   task automatic sbit(input logic b);
      sdi = b;
      tick(7);
      last_sdo = sdo;
      last_oe  = oe;
      tick(1);
      sck = 1'b1;
      tick(8);
      sck = 1'b0;
   endtask

   task automatic open_frame();
      sel_n = 1'b0;
      tick(8);
   endtask

   task automatic close_frame();
      tick(8);
      sel_n = 1'b1;
      tick(8);
   endtask

   task automatic send_head(input logic [3:0] start, input logic [3:0] op, input logic [7:0] a);
      for (int i = 3; i >= 0; i--) sbit(start[i]);
      for (int i = 3; i >= 0; i--) sbit(op[i]);
      for (int i = 0; i < 8; i++)  sbit(a[i]);
   endtask

   task automatic rd_seq(input int a, input int n, input string req);
      logic [15:0] got;
      logic        oe_all;
      open_frame();
      send_head(4'b1010, 4'b1000, 8'(a));
      for (int w = 0; w < n; w++) begin
         oe_all = 1'b1;
         for (int i = 0; i < 16; i++) begin
            sbit(1'b0);
            got[i] = last_sdo;
            oe_all = oe_all & last_oe;
         end
         chk(req, {16'h0, got}, {16'h0, model[(a + w) % NW]});
         chk(req, {31'h0, oe_all}, 32'h1);
      end
      close_frame();
   endtask

   task automatic wr(input int a, input logic [15:0] d, input int wc_at, input int stop_at);
      open_frame();
      send_head(4'b1010, 4'b0100, 8'(a));
      for (int i = 0; i < 16; i++) begin
         if (i == stop_at) break;
         if (i == wc_at) wprot = 1'b1;
         sbit(d[i]);
         wprot = 1'b0;
      end
      close_frame();
   endtask

   task automatic short_cmd(input logic [3:0] start, input logic [3:0] op, input logic [7:0] a);
      open_frame();
      send_head(start, op, a);
      close_frame();
   endtask

   task automatic wait_ready(output int waited);
      waited = 0;
      while (!rdy && waited < 2000) begin
         tick(1);
         waited++;
      end
   endtask

   function automatic logic [15:0] pat(input int a);
      return 16'(a * 16'h1357) ^ 16'hA5C3;
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int w;
      rst_n = 1'b0; sel_n = 1'b1; sck = 1'b0; sdi = 1'b0; wprot = 1'b0;
      for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
      tick(5);
      rst_n = 1'b1;
      tick(10);

      // R1 reset state and erased contents, read across all words (R4 streaming)
      chk("R1", {31'h0, rdy}, 32'h1);
      chk("R1", {31'h0, oe}, 32'h0);
      rd_seq(0, NW, "R1");

      // R5 write before any enable: no busy, word unchanged
      wr(3, 16'h1234, -1, 16);
      chk("R5", {31'h0, rdy}, 32'h1);
      rd_seq(3, 1, "R5");

      // R6 enable with write-protect high and an all-ones address
      // R12 followed, select still low, by a disable pattern that must be ignored
      wprot = 1'b1;
      open_frame();
      send_head(4'b1010, 4'b0011, 8'hFF);
      send_head(4'b1010, 4'b0000, 8'h00);
      close_frame();
      wprot = 1'b0;

      // R7 sweep every address with a computed pattern
      for (int a = 0; a < NW; a++) begin
         wr(a, pat(a), -1, 16);
         chk("R7", {31'h0, rdy}, 32'h0);
         tick(60);
         chk("R7", {31'h0, rdy}, 32'h0);
         wait_ready(w);
         chk("R7", {31'h0, rdy}, 32'h1);
         chk("R7", {31'h0, (w < 40)}, 32'h1);
         model[a] = pat(a);
      end
      chk("R6", {31'h0, oe}, 32'h0);

      // R3 single read, R4 read wrapping past the top word
      rd_seq(9, 1, "R3");
      rd_seq(13, 6, "R4");

      // R11 ready/busy on the data pin
      wr(5, 16'h0F0F, -1, 16);
      model[5] = 16'h0F0F;
      sel_n = 1'b0;
      tick(6);
      chk("R11", {30'h0, oe, sdo}, {30'h0, 2'b10});
      wait_ready(w);
      tick(3);
      chk("R11", {30'h0, oe, sdo}, {30'h0, 2'b11});
      sel_n = 1'b1;
      tick(6);
      chk("R11", {31'h0, oe}, 32'h0);

      // R8 disable frame opened during busy is ignored
      wr(6, 16'hBEEF, -1, 16);
      model[6] = 16'hBEEF;
      short_cmd(4'b1010, 4'b0000, 8'h00);
      wait_ready(w);
      wr(7, 16'h7777, -1, 16);
      chk("R8", {31'h0, rdy}, 32'h0);
      model[7] = 16'h7777;
      wait_ready(w);
      rd_seq(6, 2, "R8");

      // R2 wrong start pattern carrying a disable code, then a bad command code
      short_cmd(4'b1011, 4'b0000, 8'h00);
      short_cmd(4'b1010, 4'b1111, 8'h00);
      wr(8, 16'h1111, -1, 16);
      chk("R2", {31'h0, rdy}, 32'h0);
      model[8] = 16'h1111;
      wait_ready(w);
      rd_seq(8, 1, "R2");

      // R9 write-protect pulse in the data phase, then early deselect
      wr(2, 16'h5555, 5, 16);
      chk("R9", {31'h0, rdy}, 32'h1);
      wr(2, 16'h6666, -1, 10);
      chk("R9", {31'h0, rdy}, 32'h1);
      rd_seq(2, 1, "R9");

      // R10 write-protect during the program cycle
      wr(10, 16'hCAFE, -1, 16);
      tick(10);
      wprot = 1'b1;
      tick(8);
      chk("R10", {31'h0, rdy}, 32'h1);
      wprot = 1'b0;
      tick(4);
      rd_seq(10, 1, "R10");

      // R5 disable clears the latch
      short_cmd(4'b1010, 4'b0000, 8'h3C);
      wr(11, 16'h0000, -1, 16);
      chk("R5", {31'h0, rdy}, 32'h1);
      rd_seq(11, 1, "R5");

      summary();
      $finish;
   end

endmodule